// File: doc/BRIEF.md
# Bidirectional Cascadable Common-Row Scan Register

This block walks a single active marker across a row of common electrodes of a multiplexed passive-matrix display, one row per period of the line clock. The scan can run toward higher or lower row indices. Several copies can be chained so that they behave as one longer register. Each copy has two end ports. In master mode both end ports drive. In slave mode one of them receives the marker from the previous device, and which one depends on the scan direction. A master does not take its marker from an end port: it loads the marker from a frame-start pulse.

The line clock is brought into the system clock domain, and a phase input chooses whether its rising or its falling transition advances the scan. For every row the block produces four one-hot enables, one for each bias rail. The enable is picked from the row's active bit and the frame alternation input. The analog switches that these enables drive are outside the block.

Top module: `common_scan`

## Requirements
- R1: With `scan_up`=1, each advance loads the injected bit into row 0 and moves row i to row i+1.
- R2: With `scan_up`=0, each advance loads the injected bit into row ROWS-1 and moves row i to row i-1.
- R3: Port enables: in master mode `end_a_oe`=`end_b_oe`=1. In slave mode with `scan_up`=1, `end_a_oe`=0 and `end_b_oe`=1. In slave mode with `scan_up`=0, `end_a_oe`=1 and `end_b_oe`=0.
- R4: In slave mode the injected bit is `end_a_in` when `scan_up`=1 and `end_b_in` when `scan_up`=0. The other end input has no effect on the rows.
- R5: In master mode the injected bit is `frame_start`, and both end inputs have no effect on the rows.
- R6: The downstream port carries the last row for the direction: `end_b_out`=row ROWS-1 when `scan_up`=1, and `end_a_out`=row 0 when `scan_up`=0. The other output is 0.
- R7: Rows change only on the selected line-clock transition. Each marker therefore occupies a row for exactly one line-clock period, and the opposite transition changes nothing.
- R8: With `edge_rise`=1 the rows advance on a rising `line_clk` transition. With `edge_rise`=0 they advance on a falling transition. Rows update CL_SYNC+1 clock cycles after `line_clk` changes.
- R9: Enable bit `bias_en[4*r+k]` is set for exactly one k, where k = {`alt_m`, row r active}. The encoding is 0=V1, 1=V5, 2=V4, 3=V0.
- R10: Reset clears every row. All rows then select V1 when `alt_m`=0 and V4 when `alt_m`=1.
- R11: A slave whose upstream end input is fed from a master's downstream end output activates its first row one period after the master's last row. The pair acts as one register of twice the length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| line_clk | input | 1 | Line clock, asynchronous to clk |
| edge_rise | input | 1 | 1: advance on rising line_clk, 0: on falling |
| is_master | input | 1 | 1: master (frame_start injects), 0: slave |
| scan_up | input | 1 | 1: scan toward higher index, 0: toward lower |
| frame_start | input | 1 | Marker source in master mode |
| alt_m | input | 1 | Frame alternation polarity |
| end_a_in | input | 1 | Low-index end port, input value |
| end_a_out | output | 1 | Low-index end port, output value |
| end_a_oe | output | 1 | Low-index end port drive enable |
| end_b_in | input | 1 | High-index end port, input value |
| end_b_out | output | 1 | High-index end port, output value |
| end_b_oe | output | 1 | High-index end port drive enable |
| row_active | output | ROWS | Active bit per row |
| bias_en | output | 4*ROWS | One-hot bias rail enables, four per row |

## Verification
The bench goes after the following corner cases:
- The transition that does not advance the scan. A detector that fires on both transitions would move the marker two rows per period.
- The wrong end input in each mode. A mux built wrongly would let a master take a marker from a port, or let a slave listen to its own output side.
- The hand-off across the chained pair. A slave fed from the wrong end, or one cycle late, breaks the 128-row sequence at row 63 to row 64.
- The polarity mapping, with `alt_m` flipped while rows are both active and idle. A swapped code would select V5 where V0 belongs.

// File: rtl/common_scan_pkg.sv
package common_scan_pkg;
   // Index of the enable bit inside one row's group of four
   typedef logic [1:0] bias_code_t;
   localparam bias_code_t BIAS_V1 = 2'd0;
   localparam bias_code_t BIAS_V5 = 2'd1;
   localparam bias_code_t BIAS_V4 = 2'd2;
   localparam bias_code_t BIAS_V0 = 2'd3;
   localparam int unsigned BIAS_LEVELS = 4;

   function automatic bias_code_t bias_pick(input logic pol, input logic act);
      bias_code_t c;
      unique case ({pol, act})
         2'b00:   c = BIAS_V1;
         2'b01:   c = BIAS_V5;
         2'b10:   c = BIAS_V4;
         default: c = BIAS_V0;
      endcase
      return c;
   endfunction
endpackage

// File: rtl/common_scan_edge.sv
module common_scan_edge #(
   parameter int unsigned CL_SYNC = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic line_clk,
   input  logic edge_rise,
   output logic step
);
   logic cl_s;
   logic cl_q;

   generate
      if (CL_SYNC == 0) begin : g_direct
         assign cl_s = line_clk;
      end else begin : g_sync
         logic [CL_SYNC-1:0] sync_q;
         always_ff @(posedge clk) begin
            if (!rst_n) sync_q <= '0;
            else if (CL_SYNC == 1) sync_q <= line_clk;
            else sync_q <= {sync_q[CL_SYNC-2:0], line_clk};
         end
         assign cl_s = sync_q[CL_SYNC-1];
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) cl_q <= 1'b0;
      else        cl_q <= cl_s;
   end

   always_comb begin
      if (edge_rise) step = cl_s & ~cl_q;
      else           step = ~cl_s & cl_q;
   end
endmodule

// File: rtl/common_scan_ports.sv
module common_scan_ports #(
   parameter int unsigned ROWS = 64
) (
   input  logic            is_master,
   input  logic            scan_up,
   input  logic            frame_start,
   input  logic            end_a_in,
   input  logic            end_b_in,
   input  logic [ROWS-1:0] rows,
   output logic            inject,
   output logic            end_a_out,
   output logic            end_a_oe,
   output logic            end_b_out,
   output logic            end_b_oe
);
   logic upstream_bit;

   always_comb begin
      upstream_bit = scan_up ? end_a_in : end_b_in;
      inject       = is_master ? frame_start : upstream_bit;
      end_a_oe     = is_master | ~scan_up;
      end_b_oe     = is_master | scan_up;
      end_a_out    = ~scan_up & rows[0];
      end_b_out    = scan_up & rows[ROWS-1];
   end
endmodule

// File: rtl/common_scan_chain.sv
module common_scan_chain #(
   parameter int unsigned ROWS = 64
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            step,
   input  logic            scan_up,
   input  logic            inject,
   output logic [ROWS-1:0] rows
);
   logic [ROWS-1:0] nxt;

   generate
      for (genvar i = 0; i < ROWS; i++) begin : g_stage
         logic from_low;
         logic from_high;
         if (i == 0) begin : g_lo_end
            assign from_low = inject;
         end else begin : g_lo_mid
            assign from_low = rows[i-1];
         end
         if (i == ROWS-1) begin : g_hi_end
            assign from_high = inject;
         end else begin : g_hi_mid
            assign from_high = rows[i+1];
         end
         assign nxt[i] = scan_up ? from_low : from_high;
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n)    rows <= '0;
      else if (step) rows <= nxt;
   end
endmodule

// File: rtl/common_scan_bias.sv
module common_scan_bias
   import common_scan_pkg::*;
#(
   parameter int unsigned ROWS = 64
) (
   input  logic                        alt_m,
   input  logic [ROWS-1:0]             rows,
   output logic [BIAS_LEVELS*ROWS-1:0] bias_en
);
   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         bias_code_t code;
         assign code = bias_pick(alt_m, rows[r]);
         for (genvar k = 0; k < BIAS_LEVELS; k++) begin : g_lvl
            assign bias_en[BIAS_LEVELS*r + k] = (code == bias_code_t'(k));
         end
      end
   endgenerate
endmodule

// File: rtl/common_scan.sv
module common_scan
   import common_scan_pkg::*;
#(
   parameter int unsigned ROWS    = 64,
   parameter int unsigned CL_SYNC = 2
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic                        line_clk,
   input  logic                        edge_rise,
   input  logic                        is_master,
   input  logic                        scan_up,
   input  logic                        frame_start,
   input  logic                        alt_m,
   input  logic                        end_a_in,
   output logic                        end_a_out,
   output logic                        end_a_oe,
   input  logic                        end_b_in,
   output logic                        end_b_out,
   output logic                        end_b_oe,
   output logic [ROWS-1:0]             row_active,
   output logic [BIAS_LEVELS*ROWS-1:0] bias_en
);
   generate
      if (ROWS < 2) begin : g_bad_rows
         $error("common_scan: ROWS must be at least 2");
      end
      if (CL_SYNC > 4) begin : g_bad_sync
         $error("common_scan: CL_SYNC must not exceed 4");
      end
   endgenerate

   logic step;
   logic inject;

   common_scan_edge #(.CL_SYNC(CL_SYNC)) u_edge (
      .clk(clk), .rst_n(rst_n), .line_clk(line_clk),
      .edge_rise(edge_rise), .step(step)
   );

   common_scan_ports #(.ROWS(ROWS)) u_ports (
      .is_master(is_master), .scan_up(scan_up), .frame_start(frame_start),
      .end_a_in(end_a_in), .end_b_in(end_b_in), .rows(row_active),
      .inject(inject), .end_a_out(end_a_out), .end_a_oe(end_a_oe),
      .end_b_out(end_b_out), .end_b_oe(end_b_oe)
   );

   common_scan_chain #(.ROWS(ROWS)) u_chain (
      .clk(clk), .rst_n(rst_n), .step(step), .scan_up(scan_up),
      .inject(inject), .rows(row_active)
   );

   common_scan_bias #(.ROWS(ROWS)) u_bias (
      .alt_m(alt_m), .rows(row_active), .bias_en(bias_en)
   );
endmodule

// File: rtl/common_scan_chk.sv
module common_scan_chk #(
   parameter int unsigned ROWS = 64
) (
   input logic              clk,
   input logic              rst_n,
   input logic              step,
   input logic              is_master,
   input logic              scan_up,
   input logic              alt_m,
   input logic              end_a_oe,
   input logic              end_b_oe,
   input logic [ROWS-1:0]   row_active,
   input logic [4*ROWS-1:0] bias_en
);
   p_master_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      is_master |-> (end_a_oe && end_b_oe));
   p_slave_oe_r3: assert property (@(posedge clk) disable iff (!rst_n)
      !is_master |-> (end_a_oe != end_b_oe) && (end_b_oe == scan_up));
   p_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !step |=> $stable(row_active));
   p_shift_up_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (step && scan_up) |=> row_active[ROWS-1:1] == $past(row_active[ROWS-2:0]));
   p_shift_down_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !scan_up) |=> row_active[ROWS-2:0] == $past(row_active[ROWS-1:1]));

   generate
      for (genvar r = 0; r < ROWS; r++) begin : g_row
         p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
            $countones(bias_en[4*r +: 4]) == 1);
         p_v0_r9: assert property (@(posedge clk) disable iff (!rst_n)
            (row_active[r] && alt_m) |-> bias_en[4*r+3]);
      end
   endgenerate
endmodule

bind common_scan common_scan_chk #(.ROWS(ROWS)) u_chk (
   .clk(clk), .rst_n(rst_n), .step(step), .is_master(is_master),
   .scan_up(scan_up), .alt_m(alt_m), .end_a_oe(end_a_oe),
   .end_b_oe(end_b_oe), .row_active(row_active), .bias_en(bias_en)
);

// File: tb/common_scan_test.sv
module common_scan_test;
   localparam int R    = 64;
   localparam int HOLD = 8;

   logic clk = 1'b0;
   always #4 clk = ~clk;

   logic rst_n = 1'b0, line_clk = 1'b0, edge_rise = 1'b1, is_master = 1'b1;
   logic scan_up = 1'b1, frame_start = 1'b0, alt_m = 1'b0;
   logic a_in = 1'b0, b_in = 1'b0;
   logic a_out, a_oe, b_out, b_oe;
   logic d_a_out, d_a_oe, d_b_out, d_b_oe;
   logic [R-1:0] rows, d_rows;
   logic [4*R-1:0] bias, d_bias;
   logic [R-1:0] e1 = '0, e2 = '0;
   int vectors = 0, fails = 0;

   common_scan #(.ROWS(R)) uut (
      .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .edge_rise(edge_rise),
      .is_master(is_master), .scan_up(scan_up), .frame_start(frame_start),
      .alt_m(alt_m), .end_a_in(a_in), .end_a_out(a_out), .end_a_oe(a_oe),
      .end_b_in(b_in), .end_b_out(b_out), .end_b_oe(b_oe),
      .row_active(rows), .bias_en(bias));

   // slave fed from the master's downstream port (R11)
   common_scan #(.ROWS(R)) down (
      .clk(clk), .rst_n(rst_n), .line_clk(line_clk), .edge_rise(edge_rise),
      .is_master(1'b0), .scan_up(scan_up), .frame_start(1'b0),
      .alt_m(alt_m), .end_a_in(b_out), .end_a_out(d_a_out), .end_a_oe(d_a_oe),
      .end_b_in(a_out), .end_b_out(d_b_out), .end_b_oe(d_b_oe),
      .row_active(d_rows), .bias_en(d_bias));

   function automatic logic [4*R-1:0] exp_bias(input logic [R-1:0] e, input logic m);
      logic [4*R-1:0] v = '0;
      for (int r = 0; r < R; r++) v[4*r + {m, e[r]}] = 1'b1;
      return v;
   endfunction

   task automatic chk(input string tag, input string what,
                      input logic [4*R-1:0] act, input logic [4*R-1:0] exp);
      vectors++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   task automatic check_all(input string tag);
      chk(tag, "rows", {{(3*R){1'b0}}, rows}, {{(3*R){1'b0}}, e1});
      chk(tag, "bias", bias, exp_bias(e1, alt_m));
      chk(tag, "ports", {{(4*R-4){1'b0}}, a_oe, b_oe, a_out, b_out},
          {{(4*R-4){1'b0}}, is_master | ~scan_up, is_master | scan_up,
           ~scan_up & e1[0], scan_up & e1[R-1]});
      chk(tag, "chain rows", {{(3*R){1'b0}}, d_rows}, {{(3*R){1'b0}}, e2});
   endtask

   task automatic cl_to(input logic lvl);
      logic act, inj1, inj2;
      logic [R-1:0] o1;
      act = (lvl != line_clk) && (lvl ? edge_rise : !edge_rise);
      if (act) begin
         o1   = e1;
         inj1 = is_master ? frame_start : (scan_up ? a_in : b_in);
         inj2 = scan_up ? o1[R-1] : o1[0];
         if (scan_up) begin
            e1 = {o1[R-2:0], inj1};
            e2 = {e2[R-2:0], inj2};
         end else begin
            e1 = {inj1, o1[R-1:1]};
            e2 = {inj2, e2[R-1:1]};
         end
      end
      @(negedge clk);
      line_clk = lvl;
      repeat (HOLD) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      check_all("R10");
      alt_m = 1'b1;
      @(negedge clk);
      check_all("R10");
      alt_m = 1'b0;

      // master, upward, rising edge; end inputs must be ignored (R5)
      frame_start = 1'b1; b_in = 1'b1; a_in = 1'b0;
      cl_to(1'b1); check_all("R5");
      frame_start = 1'b0; a_in = 1'b1;
      cl_to(1'b0); check_all("R7");
      for (int p = 1; p < 2*R; p++) begin
         cl_to(1'b1);
         if (p == R-1) check_all("R6");
         else if (p == R) check_all("R11");
         else check_all("R1");
         alt_m = p[0];
         cl_to(1'b0); check_all("R9");
      end
      a_in = 1'b0; b_in = 1'b0;

      // falling-edge phase
      edge_rise = 1'b0; frame_start = 1'b1;
      cl_to(1'b1); check_all("R8");
      cl_to(1'b0); check_all("R8");
      frame_start = 1'b0;
      cl_to(1'b1); check_all("R8");
      cl_to(1'b0); check_all("R8");

      // slave, downward: injects from end_b_in only (R4), port roles (R3)
      is_master = 1'b0; scan_up = 1'b0; edge_rise = 1'b1;
      a_in = 1'b1; b_in = 1'b0;
      cl_to(1'b1); check_all("R4");
      cl_to(1'b0); check_all("R3");
      b_in = 1'b1; a_in = 1'b0;
      cl_to(1'b1); check_all("R4");
      b_in = 1'b0;
      for (int p = 0; p < 8; p++) begin
         cl_to(1'b0);
         cl_to(1'b1); check_all("R2");
      end

      // constrained random mix
      for (int n = 0; n < 300; n++) begin
         is_master   = $urandom_range(0, 1);
         scan_up     = $urandom_range(0, 3) != 0;
         edge_rise   = $urandom_range(0, 1);
         alt_m       = $urandom_range(0, 1);
         frame_start = $urandom_range(0, 7) == 0;
         a_in        = $urandom_range(0, 7) == 0;
         b_in        = $urandom_range(0, 7) == 0;
         cl_to(1'b1); check_all("R7");
         cl_to(1'b0); check_all("R9");
      end

      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial void'($urandom(32'd1234));
endmodule